// File: doc/BRIEF.md
# Wave Sample RAM Access Arbiter

This block holds a 16-byte wave sample store and decides, for each CPU access, which byte the access really reaches, or whether it is refused. The store packs 32 four-bit samples, two per byte, the earlier sample of each pair in the upper nibble. A sound channel scans the store through its own read port. The scan is driven by a 5-bit sample position and a one-cycle fetch pulse that marks the cycle in which the channel takes its byte.

When the channel is idle, the CPU reaches the byte it names. While the channel plays, the CPU is steered to the byte the channel is reading. On the earlier hardware generation this works only in the fetch cycle. Outside it, reads give 0xFF and writes are lost. On the later generation, reads are always steered to the channel's byte, but writes still go to the byte the CPU names. Sample playback, frequency timing and volume scaling live outside this block.

Top module: `wave_ram_arbiter`

## Requirements
- R1: After reset, every byte of the store holds 0x00 and `cpu_rdata` is 0x00.
- R2: With `ch_playing` low, a write stores `cpu_wdata` in the byte at `cpu_addr`.
- R3: With `ch_playing` low, a read with `cpu_rd` high loads the byte at `cpu_addr` into `cpu_rdata` at the next clock edge.
- R4: With `ch_playing` high, `later_model` low and `ch_fetch` high, a read returns the byte at index `ch_pos >> 1`, whatever `cpu_addr` is.
- R5: With `ch_playing` high, `later_model` low and `ch_fetch` low, a read returns 0xFF.
- R6: With `ch_playing` high, `later_model` low and `ch_fetch` high, a write lands in byte `ch_pos >> 1` and the byte at `cpu_addr` is left unchanged.
- R7: With `ch_playing` high, `later_model` low and `ch_fetch` low, a write changes no byte.
- R8: With `ch_playing` high and `later_model` high, a read returns byte `ch_pos >> 1` whatever `ch_fetch` and `cpu_addr` are.
- R9: With `ch_playing` high and `later_model` high, a write lands in the byte at `cpu_addr` whatever `ch_fetch` is, and byte `ch_pos >> 1` is left alone.
- R10: `ch_sample` is combinational from byte `ch_pos >> 1`. It is the upper nibble (bits 7:4) when `ch_pos[0]` is 0 and the lower nibble (bits 3:0) when it is 1.
- R11: When a write reaches the channel's byte in the fetch cycle, `ch_sample` shows the old contents in that cycle and the new contents from the next cycle on.
- R12: While `cpu_rd` is low, `cpu_rdata` keeps its value, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 4 | CPU byte offset in the wave store |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| ch_playing | input | 1 | Channel is playing |
| ch_pos | input | 5 | Channel's current sample position |
| ch_fetch | input | 1 | One-cycle pulse: the channel fetches its byte this cycle |
| later_model | input | 1 | 0 selects the earlier generation's behaviour, 1 the later |
| cpu_rdata | output | 8 | Registered CPU read data |
| ch_sample | output | 4 | Sample at the channel position |

## Verification
The hardest case to reach is the collision in R11. In the fetch cycle of the earlier generation, a CPU write is steered onto the same byte the channel is reading, so the old and new contents must be told apart inside one cycle. The bench holds a playing, fetching position and writes to an unrelated address. It samples `ch_sample` just after the inputs settle, before the edge, and again one cycle later. It then reads back both the steered byte and the named address with the channel idle. This proves the write went to the position and not to the address.

// File: rtl/wave_arb_pkg.sv
package wave_arb_pkg;
  localparam int DATA_W   = 8;
  localparam int SAMPLE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  typedef enum logic {
    GEN_EARLY = 1'b0,
    GEN_LATE  = 1'b1
  } gen_e;
endpackage

// File: rtl/wave_arb_route.sv
module wave_arb_route #(
  parameter int AW = 4
) (
  input  logic          playing,
  input  logic          fetch,
  input  logic          late_gen,
  input  logic          wr_req,
  input  logic [AW-1:0] cpu_idx,
  input  logic [AW-1:0] ch_idx,
  output logic          wr_go,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic          rd_block
);
  import wave_arb_pkg::*;

  gen_e gen;

  always_comb begin
    gen      = gen_e'(late_gen);
    wr_go    = wr_req;
    wr_idx   = cpu_idx;
    rd_idx   = cpu_idx;
    rd_block = 1'b0;
    if (playing) begin
      rd_idx = ch_idx;
      if (gen == GEN_EARLY) begin
        wr_idx   = ch_idx;
        wr_go    = wr_req && fetch;
        rd_block = !fetch;
      end
    end
  end
endmodule

// File: rtl/wave_arb_store.sv
module wave_arb_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] cidx,
  output logic [DW-1:0] cdata
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic          en;
    logic [DW-1:0] d;
    always_comb begin
      en = we && (widx == AW'(i));
      d  = en ? wdata : mem_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else if (en) mem_q[i] <= d;
    end
  end

  assign rdata = mem_q[ridx];
  assign cdata = mem_q[cidx];

  // R2 / R6 / R9: an accepted write is visible at its index one cycle later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(widx)] == $past(wdata));

  // R7: no accepted write leaves every byte as it was
  a_r7_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> mem_q == $past(mem_q));
endmodule

// File: rtl/wave_ram_arbiter.sv
module wave_ram_arbiter #(
  parameter int NUM_SAMPLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  input  logic       ch_playing,
  input  logic [4:0] ch_pos,
  input  logic       ch_fetch,
  input  logic       later_model,
  output logic [7:0] cpu_rdata,
  output logic [3:0] ch_sample
);
  import wave_arb_pkg::*;

  localparam int BYTES = NUM_SAMPLES / 2;
  localparam int AW    = $clog2(BYTES);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic          wr_go, rd_block;
  logic [AW-1:0] wr_idx, rd_idx, ch_idx;
  logic [7:0]    rd_byte, ch_byte;

  assign ch_idx = ch_pos[AW:1];

  wave_arb_route #(.AW(AW)) u_route (
    .playing  (ch_playing),
    .fetch    (ch_fetch),
    .late_gen (later_model),
    .wr_req   (cpu_wr),
    .cpu_idx  (cpu_addr[AW-1:0]),
    .ch_idx   (ch_idx),
    .wr_go    (wr_go),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .rd_block (rd_block)
  );

  wave_arb_store #(.DEPTH(BYTES), .DW(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_go),
    .widx  (wr_idx),
    .wdata (cpu_wdata),
    .ridx  (rd_idx),
    .rdata (rd_byte),
    .cidx  (ch_idx),
    .cdata (ch_byte)
  );

  logic [7:0] rdata_d;
  logic       rdata_en;

  always_comb begin
    rdata_en = cpu_rd;
    rdata_d  = rd_block ? OPEN_BUS : rd_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   cpu_rdata <= '0;
    else if (rdata_en) cpu_rdata <= rdata_d;
  end

  assign ch_sample = ch_pos[0] ? ch_byte[SAMPLE_W-1:0] : ch_byte[DATA_W-1:SAMPLE_W];

  // R4: early generation, fetch cycle: read follows the channel byte
  a_r4_fetch_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_rd && ch_playing && !later_model && ch_fetch |=> cpu_rdata == $past(ch_byte));

  // R5: early generation outside the fetch cycle: open-bus value
  a_r5_blocked_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_rd && ch_playing && !later_model && !ch_fetch |=> cpu_rdata == 8'hFF);

  // R7: early generation outside the fetch cycle: write refused
  a_r7_write_dropped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ch_playing && !later_model && !ch_fetch |-> !wr_go);

  // R8: later generation: read follows the channel byte
  a_r8_late_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_rd && ch_playing && later_model |=> cpu_rdata == $past(ch_byte));

  // R9: later generation: write goes to the CPU address
  a_r9_late_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wr && ch_playing && later_model |-> wr_go && wr_idx == cpu_addr[AW-1:0]);

  // R12: read data held while no read is requested
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

// File: tb/wave_ram_arbiter_tb.sv
module wave_ram_arbiter_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       ch_playing = 1'b0, ch_fetch = 1'b0, later_model = 1'b0;
  logic [4:0] ch_pos = '0;
  logic [7:0] cpu_rdata;
  logic [3:0] ch_sample;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  wave_ram_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .ch_playing(ch_playing), .ch_pos(ch_pos), .ch_fetch(ch_fetch),
    .later_model(later_model), .cpu_rdata(cpu_rdata), .ch_sample(ch_sample)
  );

  // wr rd addr wdata play pos fetch later expected
  localparam logic [29:0] VECS [0:NV-1] = '{
    {1'b1,1'b0,4'h0,8'h11,1'b0,5'd0 ,1'b0,1'b0,8'h00}, // R2
    {1'b1,1'b0,4'h5,8'h5A,1'b0,5'd0 ,1'b0,1'b0,8'h00}, // R2
    {1'b1,1'b0,4'hF,8'hC3,1'b0,5'd0 ,1'b0,1'b0,8'h00}, // R2
    {1'b0,1'b1,4'h5,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h5A}, // R3
    {1'b0,1'b1,4'h0,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h11}, // R3
    {1'b0,1'b1,4'h0,8'h00,1'b1,5'd10,1'b1,1'b0,8'h5A}, // R4
    {1'b0,1'b1,4'h2,8'h00,1'b1,5'd31,1'b1,1'b0,8'hC3}, // R4
    {1'b0,1'b1,4'h5,8'h00,1'b1,5'd10,1'b0,1'b0,8'hFF}, // R5
    {1'b1,1'b0,4'h9,8'h77,1'b1,5'd6 ,1'b1,1'b0,8'h00}, // R6
    {1'b0,1'b1,4'h3,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h77}, // R6
    {1'b0,1'b1,4'h9,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h00}, // R6
    {1'b1,1'b0,4'h3,8'hEE,1'b1,5'd6 ,1'b0,1'b0,8'h00}, // R7
    {1'b0,1'b1,4'h3,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h77}, // R7
    {1'b0,1'b1,4'h0,8'h00,1'b1,5'd0 ,1'b0,1'b1,8'h11}, // R8
    {1'b0,1'b1,4'h7,8'h00,1'b1,5'd11,1'b1,1'b1,8'h5A}, // R8
    {1'b1,1'b0,4'h8,8'h3C,1'b1,5'd0 ,1'b0,1'b1,8'h00}, // R9
    {1'b1,1'b0,4'hA,8'hD2,1'b1,5'd0 ,1'b1,1'b1,8'h00}, // R9
    {1'b0,1'b1,4'h8,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h3C}, // R9
    {1'b0,1'b1,4'hA,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'hD2}, // R9
    {1'b0,1'b1,4'h0,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h11}, // R9
    {1'b0,1'b1,4'h3,8'h00,1'b0,5'd0 ,1'b0,1'b0,8'h77}  // R7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr = 1'b0; cpu_rd = 1'b0; ch_playing = 1'b0; ch_fetch = 1'b0; later_model = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rdata", cpu_rdata, 8'h00);
    for (int a = 0; a < 16; a++) begin
      cpu_rd = 1'b1; cpu_addr = 4'(a);
      @(negedge clk);
      chk("R1 byte", cpu_rdata, 8'h00);
    end
    idle();

    for (int i = 0; i < NV; i++) begin
      cpu_wr      = VECS[i][29];
      cpu_rd      = VECS[i][28];
      cpu_addr    = VECS[i][27:24];
      cpu_wdata   = VECS[i][23:16];
      ch_playing  = VECS[i][15];
      ch_pos      = VECS[i][14:10];
      ch_fetch    = VECS[i][9];
      later_model = VECS[i][8];
      @(negedge clk);
      if (VECS[i][28]) chk($sformatf("vector %0d (R2-R9 table)", i), cpu_rdata, VECS[i][7:0]);
    end
    idle();

    // R10: nibble order of the channel sample
    ch_pos = 5'd10; #1; chk("R10 pos10", {4'h0, ch_sample}, 8'h05);
    ch_pos = 5'd11; #1; chk("R10 pos11", {4'h0, ch_sample}, 8'h0A);
    ch_pos = 5'd30; #1; chk("R10 pos30", {4'h0, ch_sample}, 8'h0C);
    ch_pos = 5'd31; #1; chk("R10 pos31", {4'h0, ch_sample}, 8'h03);
    @(negedge clk);

    // R11: collision in the fetch cycle
    ch_playing = 1'b1; later_model = 1'b0; ch_fetch = 1'b1; ch_pos = 5'd4;
    cpu_wr = 1'b1; cpu_addr = 4'hC; cpu_wdata = 8'h9B;
    #1; chk("R11 old value", {4'h0, ch_sample}, 8'h00);
    @(negedge clk);
    idle();
    #1; chk("R11 new value", {4'h0, ch_sample}, 8'h09);
    ch_pos = 5'd5; #1; chk("R11 low nibble", {4'h0, ch_sample}, 8'h0B);
    cpu_rd = 1'b1; cpu_addr = 4'h2;
    @(negedge clk);
    chk("R11 steered byte", cpu_rdata, 8'h9B);
    cpu_addr = 4'hC;
    @(negedge clk);
    chk("R11 named byte untouched", cpu_rdata, 8'h00);

    // R12: hold while no read
    cpu_addr = 4'h5;
    @(negedge clk);
    chk("R12 setup", cpu_rdata, 8'h5A);
    cpu_rd = 1'b0; cpu_addr = 4'hF;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 4'h5; cpu_wdata = 8'h00;
    @(negedge clk);
    cpu_wr = 1'b0;
    @(negedge clk);
    chk("R12 held", cpu_rdata, 8'h5A);

    // R1: second reset clears the store
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 4'h3;
    @(negedge clk);
    chk("R1 after re-reset", cpu_rdata, 8'h00);
    idle();
    finish_run();
  end
endmodule